// File: doc/BRIEF.md
# Daisy-Chain Serial Host Controller

This block drives a chain of serial slave devices that share one serial clock and one combined chip-select/load strobe. The data output of each device feeds the data input of the next, so the whole chain behaves as one long shift register. The host presents one 32-bit instruction word per device and a per-device flag that says whether that device has work to do. A start pulse then runs one frame. The strobe drops, the concatenated stream is shifted out, and the strobe rises again so that every device executes its word at the same moment. Devices without a pending word receive a no-operation word.

The controller also samples the data coming back from the far end of the chain on every rising clock edge. It presents those bits as one word per chain slot when the frame completes. The serial clock comes from a programmable divider of the system clock. Between frames a guard interval keeps the strobe high.

Top module: `dchain_host`

## Requirements
- R1: While reset is held, and in the cycle after it, the outputs are: strobe `cs_ld` high, `sck` low, `sdi` low, `busy` low, `rd_valid` low and `rd_word` zero.
- R2: A `start` pulse begins a frame only when the controller is idle. A pulse during a frame or during the guard interval starts no frame and does not change the frame in progress.
- R3: Slot k of `dev_word` (bits 32k+31..32k) is meant for device k, where device 0 takes `sdi` directly. The stream is sent slot N_DEV-1 first, each word MSB first. When the strobe rises, device k therefore holds slot k.
- R4: A slot whose `dev_valid` bit is 0 is replaced by the no-operation word. In that word the command field (bits 23..20) is 1111 and every other bit is 0, giving 32'h00F0_0000.
- R5: Each frame has exactly N_DEV*32 rising edges of `sck` while `cs_ld` is low. `sck` stays low whenever `cs_ld` is high.
- R6: With H = `div_half`+1 system clocks: the first `sck` rise comes H clocks after `cs_ld` falls, each `sck` phase lasts H clocks, and `cs_ld` rises H clocks after the last falling edge. `cs_ld` is therefore low for H*(2*N_DEV*32+1) clocks.
- R7: `sdi` changes only while `sck` is low, that is, together with a falling edge or before the first rise. It is stable at every rising edge.
- R8: `busy` is high exactly while `cs_ld` is low.
- R9: Between two frames `cs_ld` stays high for at least 4*H system clocks, which is two `sck` periods.
- R10: `sdo` is sampled on each `sck` rise, and the first sample lands in the MSB of `rd_word`. `rd_word` updates in the cycle in which `cs_ld` rises, `rd_valid` pulses for that one cycle, and `rd_word` holds its value until the next frame ends.
- R11: `dev_word`, `dev_valid` and `div_half` are taken at the accepted start. Changing them during a frame affects neither its data nor its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one frame (accepted when idle) |
| div_half | input | DIV_W | SCK half period minus one, in system clocks |
| dev_word | input | N_DEV*WORD_W | Per-device instruction words, slot k for device k |
| dev_valid | input | N_DEV | Per-device pending flag; 0 sends the no-operation word |
| sdo | input | 1 | Serial data returned from the last device |
| sck | output | 1 | Shared serial clock |
| sdi | output | 1 | Serial data into the first device |
| cs_ld | output | 1 | Shared active-low select, rising edge loads |
| busy | output | 1 | High while a frame holds the strobe low |
| rd_word | output | N_DEV*WORD_W | Bits returned from the chain, first sample at MSB |
| rd_valid | output | 1 | One-cycle pulse when `rd_word` updates |

## Verification
The bench builds the block with two devices (a 64-bit stream) and a 2-bit divider field. With these values it can run every divider setting against every combination of idle and active devices, 16 frames in all, while a behavioural model of the chain checks placement and readback. The small divider keeps frames short enough to add a held-start back-to-back pair, which measures the guard interval. It also adds start pulses and input changes placed inside a frame and inside the guard interval.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_TRAIL,
    ST_GAP
  } dc_state_t;
endpackage

// File: rtl/dchain_word_mux.sv
module dchain_word_mux #(
  parameter int unsigned N_DEV   = 4,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned CMD_LSB = 20,
  parameter logic [3:0]  NOP_CMD = 4'hF
) (
  input  logic [N_DEV*WORD_W-1:0] word_in,
  input  logic [N_DEV-1:0]        valid,
  output logic [N_DEV*WORD_W-1:0] stream
);
  localparam logic [WORD_W-1:0] NOP_WORD =
    {{(WORD_W-4){1'b0}}, NOP_CMD} << CMD_LSB;

  // slot k stays at bits k*WORD_W; MSB-first shifting sends the far device first
  for (genvar g = 0; g < N_DEV; g++) begin : g_slot
    assign stream[g*WORD_W +: WORD_W] = valid[g] ? word_in[g*WORD_W +: WORD_W] : NOP_WORD;
  end
endmodule

// File: rtl/dchain_timer.sv
module dchain_timer #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/dchain_fsm.sv
module dchain_fsm
  import dchain_pkg::*;
#(
  parameter int unsigned NBITS = 128,
  parameter int unsigned DIV_W = 8,
  parameter int unsigned CNT_W = DIV_W + 3,
  parameter int unsigned BIT_W = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DIV_W-1:0] div_half,
  input  logic             tick,
  output logic             run,
  output logic [CNT_W-1:0] limit,
  output logic             load,
  output logic             rise_ev,
  output logic             fall_ev,
  output logic             done,
  output logic             sck,
  output logic             cs_ld,
  output logic             busy
);
  dc_state_t        state;
  logic [DIV_W-1:0] half_q;
  logic [BIT_W-1:0] bit_cnt;
  logic [CNT_W-1:0] hp1;
  logic             last;

  assign hp1     = CNT_W'(half_q) + CNT_W'(1);
  assign limit   = (state == ST_GAP) ? ((hp1 << 2) - CNT_W'(1)) : CNT_W'(half_q);
  assign run     = (state != ST_IDLE);
  assign load    = (state == ST_IDLE) && start;
  assign rise_ev = (state == ST_SHIFT) && tick && !sck;
  assign fall_ev = (state == ST_SHIFT) && tick && sck;
  assign done    = (state == ST_TRAIL) && tick;
  assign last    = (bit_cnt == BIT_W'(NBITS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      sck     <= 1'b0;
      cs_ld   <= 1'b1;
      busy    <= 1'b0;
      half_q  <= '0;
      bit_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_SHIFT;
            cs_ld   <= 1'b0;
            busy    <= 1'b1;
            half_q  <= div_half;
            bit_cnt <= '0;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!sck) begin
              sck <= 1'b1;
            end else begin
              sck <= 1'b0;
              if (last) state   <= ST_TRAIL;
              else      bit_cnt <= bit_cnt + BIT_W'(1);
            end
          end
        end
        ST_TRAIL: begin
          if (tick) begin
            state <= ST_GAP;
            cs_ld <= 1'b1;
            busy  <= 1'b0;
          end
        end
        ST_GAP: begin
          if (tick) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dchain_datapath.sv
module dchain_datapath #(
  parameter int unsigned NBITS = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [NBITS-1:0] stream,
  input  logic             rise_ev,
  input  logic             fall_ev,
  input  logic             done,
  input  logic             sdo,
  output logic             sdi,
  output logic [NBITS-1:0] rd_word,
  output logic             rd_valid
);
  logic [NBITS-1:0] tx_sr;
  logic [NBITS-1:0] rx_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr    <= '0;
      rx_sr    <= '0;
      sdi      <= 1'b0;
      rd_word  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= done;
      if (load) begin
        sdi   <= stream[NBITS-1];
        tx_sr <= {stream[NBITS-2:0], 1'b0};
      end else if (fall_ev) begin
        sdi   <= tx_sr[NBITS-1];
        tx_sr <= {tx_sr[NBITS-2:0], 1'b0};
      end
      if (rise_ev) rx_sr   <= {rx_sr[NBITS-2:0], sdo};
      if (done)    rd_word <= rx_sr;
    end
  end
endmodule

// File: rtl/dchain_host.sv
module dchain_host #(
  parameter int unsigned N_DEV   = 4,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned CMD_LSB = 20,
  parameter logic [3:0]  NOP_CMD = 4'hF
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [DIV_W-1:0]        div_half,
  input  logic [N_DEV*WORD_W-1:0] dev_word,
  input  logic [N_DEV-1:0]        dev_valid,
  input  logic                    sdo,
  output logic                    sck,
  output logic                    sdi,
  output logic                    cs_ld,
  output logic                    busy,
  output logic [N_DEV*WORD_W-1:0] rd_word,
  output logic                    rd_valid
);
  localparam int unsigned NBITS = N_DEV * WORD_W;
  localparam int unsigned CNT_W = DIV_W + 3;

  logic [NBITS-1:0] stream;
  logic             run, tick, load, rise_ev, fall_ev, done;
  logic [CNT_W-1:0] limit;

  dchain_word_mux #(
    .N_DEV(N_DEV), .WORD_W(WORD_W), .CMD_LSB(CMD_LSB), .NOP_CMD(NOP_CMD)
  ) u_mux (
    .word_in(dev_word), .valid(dev_valid), .stream(stream)
  );

  dchain_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .run(run), .limit(limit), .tick(tick)
  );

  dchain_fsm #(.NBITS(NBITS), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst), .start(start), .div_half(div_half), .tick(tick),
    .run(run), .limit(limit), .load(load), .rise_ev(rise_ev),
    .fall_ev(fall_ev), .done(done), .sck(sck), .cs_ld(cs_ld), .busy(busy)
  );

  dchain_datapath #(.NBITS(NBITS)) u_dp (
    .clk(clk), .rst(rst), .load(load), .stream(stream), .rise_ev(rise_ev),
    .fall_ev(fall_ev), .done(done), .sdo(sdo), .sdi(sdi),
    .rd_word(rd_word), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/dchain_host_chk.sv
module dchain_host_chk #(
  parameter int unsigned NBITS = 128
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic sck,
  input logic sdi,
  input logic cs_ld,
  input logic busy,
  input logic rd_valid
);
  logic        sck_q;
  logic [31:0] rise_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q    <= 1'b0;
      rise_cnt <= '0;
    end else begin
      sck_q    <= sck;
      rise_cnt <= cs_ld ? 32'd0 : rise_cnt + {31'd0, (sck && !sck_q)};
    end
  end

  assert_sck_idle_R5: assert property (@(posedge clk) disable iff (rst)
    cs_ld |-> !sck);

  assert_frame_len_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_ld) |-> (rise_cnt == 32'(NBITS)));

  assert_cs_rise_low_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_ld) |-> !sck);

  assert_sdi_hold_R7: assert property (@(posedge clk) disable iff (rst)
    sck |-> $stable(sdi));

  assert_busy_R8: assert property (@(posedge clk) disable iff (rst)
    busy == !cs_ld);

  assert_rdv_R10: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (cs_ld && !$past(cs_ld)));

  assert_start_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_ld) |-> $past(start));
endmodule

bind dchain_host dchain_host_chk #(.NBITS(N_DEV * WORD_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .sck(sck), .sdi(sdi),
  .cs_ld(cs_ld), .busy(busy), .rd_valid(rd_valid)
);

// File: tb/dchain_host_tb.sv
`timescale 1ns/1ps
module dchain_host_tb;
  localparam int N  = 2;
  localparam int L  = 64;
  localparam int DW = 2;
  localparam logic [31:0] NOP = 32'h00F0_0000;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [DW-1:0] div_half = '0;
  logic [L-1:0]  dev_word = '0;
  logic [N-1:0]  dev_valid = '0;
  logic [L-1:0]  chain = 64'hC3A5_0F1E_9B2D_7486;
  logic          sdo = 1'b1;
  logic [L-1:0]  snap = '0;
  logic [L-1:0]  prev = 64'hC3A5_0F1E_9B2D_7486;
  logic sck, sdi, cs_ld, busy, rd_valid;
  logic [L-1:0] rd_word;

  int n_chk = 0, n_fail = 0;
  int low_cyc = 0, rises = 0, lead = 0, sdi_bad = 0, idle_bad = 0, busy_bad = 0;
  int falls = 0, high_run = 0, last_gap = 0;
  bit seen_rise = 0;
  logic sck_q = 1'b0, sdi_q = 1'b0, cs_q = 1'b1;

  always #2 clk = ~clk;

  dchain_host #(.N_DEV(N), .WORD_W(32), .DIV_W(DW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .div_half(div_half),
    .dev_word(dev_word), .dev_valid(dev_valid), .sdo(sdo), .sck(sck),
    .sdi(sdi), .cs_ld(cs_ld), .busy(busy), .rd_word(rd_word), .rd_valid(rd_valid)
  );

  // behavioural chain: samples on rise, drives its output on fall
  always @(posedge sck) chain <= {chain[L-2:0], sdi};
  always @(negedge sck) sdo <= chain[L-1];
  always @(posedge cs_ld) snap = chain;

  always @(negedge clk) begin
    if (!rst) begin
      if (!cs_ld) begin
        low_cyc++;
        if (sck && !sck_q) rises++;
        if (!seen_rise && !sck) lead++;
        if (sck) seen_rise = 1;
        if (sck && sdi !== sdi_q) sdi_bad++;
        if (cs_q) begin falls++; last_gap = high_run; high_run = 0; end
      end else begin
        high_run++;
        if (sck) idle_bad++;
      end
      if (busy === cs_ld) busy_bad++;
    end
    sck_q = sck; sdi_q = sdi; cs_q = cs_ld;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [L-1:0] mk_stream(input logic [L-1:0] w, input logic [N-1:0] v);
    logic [L-1:0] s;
    for (int k = 0; k < N; k++) s[k*32 +: 32] = v[k] ? w[k*32 +: 32] : NOP;
    return s;
  endfunction

  task automatic clr_stats();
    low_cyc = 0; rises = 0; lead = 0; seen_rise = 0; sdi_bad = 0; falls = 0;
  endtask

  task automatic wait_done();
    while (rd_valid !== 1'b1) @(negedge clk);
  endtask

  task automatic frame_checks(input logic [L-1:0] exp, input int h);
    chk(snap == exp, "R3/R4 chain contents", snap, exp);
    chk(rd_word == prev, "R10 readback", rd_word, prev);
    chk(rises == L, "R5 rise count", 64'(rises), 64'(L));
    chk(low_cyc == h*(2*L+1), "R6 strobe low length", 64'(low_cyc), 64'(h*(2*L+1)));
    chk(lead == h, "R6 lead time", 64'(lead), 64'(h));
    chk(sdi_bad == 0, "R7 sdi change while sck high", 64'(sdi_bad), 0);
    chk(falls == 1, "R2 single frame", 64'(falls), 1);
    prev = exp;
  endtask

  task automatic do_frame(input logic [L-1:0] w, input logic [N-1:0] v, input int half,
                          input bit poke_start, input bit poke_cfg);
    logic [L-1:0] exp;
    logic [L-1:0] got;
    exp = mk_stream(w, v);
    @(negedge clk);
    dev_word = w; dev_valid = v; div_half = DW'(half);
    clr_stats();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !cs_ld, "R8 busy at frame start", {62'd0, busy, cs_ld}, 64'h2);
    if (poke_start || poke_cfg) begin
      repeat (40) @(negedge clk);
      if (poke_cfg) begin
        dev_word = ~w; dev_valid = ~v; div_half = DW'(half) ^ 2'b10;
      end
      if (poke_start) begin
        start = 1'b1; dev_word = ~w;
        @(negedge clk);
        start = 1'b0;
      end
    end
    wait_done();
    frame_checks(exp, half + 1);
    got = rd_word;
    repeat (4*(half+1) + 4) @(negedge clk);
    chk(rd_word == got, "R10 readback holds", rd_word, got);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R2 run did not finish actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_ld === 1'b1 && sck === 1'b0 && sdi === 1'b0 && busy === 1'b0 && rd_valid === 1'b0
        && rd_word === '0, "R1 reset state", {58'd0, cs_ld, sck, sdi, busy, rd_valid, |rd_word}, 64'h20);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_ld === 1'b1 && sck === 1'b0 && busy === 1'b0, "R1 after reset",
        {61'd0, cs_ld, sck, busy}, 64'h4);

    // full sweep: every divider value against every idle/active mask
    for (int h = 0; h < 4; h++) begin
      for (int m = 0; m < 4; m++) begin
        logic [31:0] w1, w0;
        w1 = 32'h8765_4321 ^ 32'((h*16+m) * 32'h0101_0101);
        w0 = 32'h0F1E_2D3C + 32'((h*16+m) * 32'h1111);
        do_frame({w1, w0}, N'(m), h, 1'b0, 1'b0);
      end
    end

    // R2: start pulse inside a frame; R11: inputs change inside a frame
    do_frame(64'h1234_5678_9ABC_DEF0, 2'b11, 1, 1'b1, 1'b0);
    do_frame(64'hFEDC_BA98_7654_3210, 2'b01, 1, 1'b0, 1'b1);

    // R2: start pulse during the guard interval is ignored
    begin
      @(negedge clk);
      dev_word = 64'h5555_AAAA_3333_CCCC; dev_valid = 2'b11; div_half = 2'd3;
      clr_stats(); start = 1'b1;
      @(negedge clk); start = 1'b0;
      wait_done();
      frame_checks(64'h5555_AAAA_3333_CCCC, 4);
      @(negedge clk);
      clr_stats(); start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (20) @(negedge clk);
      chk(falls == 0 && cs_ld === 1'b1, "R2 start in guard ignored", 64'(falls), 0);
      repeat (4) @(negedge clk);
    end

    // R9: held start gives back-to-back frames separated by the guard
    begin
      logic [L-1:0] e;
      e = mk_stream(64'h0BAD_F00D_CAFE_1234, 2'b10);
      @(negedge clk);
      dev_word = 64'h0BAD_F00D_CAFE_1234; dev_valid = 2'b10; div_half = 2'd2;
      clr_stats(); start = 1'b1;
      wait_done();
      frame_checks(e, 3);
      clr_stats();
      while (falls == 0) @(negedge clk);
      start = 1'b0;
      chk(last_gap >= 12, "R9 guard interval", 64'(last_gap), 64'd12);
      wait_done();
      frame_checks(e, 3);
      repeat (16) @(negedge clk);
    end

    chk(idle_bad == 0, "R5 sck idle while strobe high", 64'(idle_bad), 0);
    chk(busy_bad == 0, "R8 busy tracks strobe", 64'(busy_bad), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule